// File: doc/BRIEF.md
# PCM Companding Code Formatter

This block translates voice samples between a 14-bit two's-complement linear form and an 8-bit companded PCM byte. Bytes carry one sample each on a 64 kb/s channel at an 8 kHz sample rate. It has two independent directions. The transmit direction takes a linear sample and returns a byte. The receive direction takes a byte and returns a linear sample.

Two configuration bits control both directions. The first selects A-law or µ-law segment companding. The second selects the code assignment on the byte side: either the standard inversion rules or plain sign-magnitude. The two bits can be set in any combination. They are loaded together through a write strobe, and reset places them at µ-law with standard coding. Each direction is a single registered stage that takes a valid strobe in and gives a valid strobe out.

Top module: `pcm_compander`

## Requirements
- R1: After reset both output valids are low, and the configuration is µ-law with standard coding, with no write needed.
- R2: µ-law, standard coding: mag = (x<0 ? -x-1 : x), b = min(mag+33, 8191), seg = index of the top set bit of b minus 5 (0..7), step = bits seg+4..seg+1 of b. The byte is {x>=0, ~{seg[2:0],step[3:0]}}.
- R3: A-law, standard coding: m = mag>>1. If m<32 then seg=0 and step=m>>1; otherwise seg = index of the top set bit of m minus 4, and step = bits seg+3..seg of m. The byte is {x>=0, seg, step} XOR 8'h55.
- R4: With sign-magnitude coding selected, the byte is {x>=0, seg, step}, with no inversion, under either law.
- R5: µ-law decode: the byte is first un-inverted per the selected coding. Then r = ((2*step+33)<<seg) - 33, and the output is r when bit 7 = 1, else -r-1.
- R6: A-law decode: the byte is first un-inverted per the selected coding. r = 2*step+1 for seg 0, else (16+step)<<seg plus 1<<(seg-1). The output is 2r when bit 7 = 1, else -2r-1.
- R7: Sign-magnitude decode reads the byte with no inversion under either law.
- R8: Each output and its valid register one clock after an input valid. Without an input valid, the output valid is low on the next clock and the data output holds.
- R9: Configuration bits are taken only when the write strobe is high, and they apply to samples accepted after that clock edge.
- R10: µ-law magnitudes past the top segment clip to the top code. With standard coding, x=8191 gives 8'h80 and x=-8192 gives 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgALaw | input | 1 | 1 = A-law, 0 = µ-law |
| cfgSignMag | input | 1 | 1 = sign-magnitude, 0 = standard coding |
| encValid | input | 1 | Linear sample valid |
| encLinear | input | 14 | Linear sample, two's complement |
| encOutValid | output | 1 | Encoded byte valid |
| encByte | output | 8 | Encoded PCM byte |
| decValid | input | 1 | PCM byte valid |
| decByte | input | 8 | PCM byte to decode |
| decOutValid | output | 1 | Decoded sample valid |
| decLinear | output | 14 | Decoded linear sample |

## Verification
The hardest cases to reach are the segment edges and the clip region at the far ends of the linear range. Off-by-one errors in the bias or the leading-one search show up only there. The bench therefore sweeps all 16384 linear codes and all 256 bytes under each of the four law and coding combinations. It holds the valid strobe high continuously, so that every accepted sample is compared, back to back, against an arithmetic model. It also drives the configuration inputs with the write strobe low during traffic. This shows that the configuration is kept when the strobe is low, and only a port-level comparison can show that.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int LIN_W  = 14;
  localparam int CODE_W = 8;
  localparam int MAG_W  = LIN_W - 1;
  localparam int SEG_W  = 3;
  localparam int STEP_W = 4;
  localparam logic [CODE_W-1:0] ADI_MASK = 8'h55;
  localparam logic [MAG_W:0]    MU_BIAS  = 14'd33;

  typedef struct packed {
    logic encLoad;
    logic decLoad;
    logic aLaw;
    logic signMag;
  } ctlStrobes_t;
endpackage

// File: rtl/pcm_ctrl.sv
module pcm_ctrl
  import pcm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgALaw,
  input  logic        cfgSignMag,
  input  logic        encValid,
  input  logic        decValid,
  output ctlStrobes_t strobes,
  output logic        encOutValid,
  output logic        decOutValid
);
  logic aLawQ, signMagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aLawQ       <= 1'b0;
      signMagQ    <= 1'b0;
      encOutValid <= 1'b0;
      decOutValid <= 1'b0;
    end else begin
      if (cfgWrEn) begin
        aLawQ    <= cfgALaw;
        signMagQ <= cfgSignMag;
      end
      encOutValid <= encValid;
      decOutValid <= decValid;
    end
  end

  always_comb begin
    strobes.encLoad = encValid;
    strobes.decLoad = decValid;
    strobes.aLaw    = aLawQ;
    strobes.signMag = signMagQ;
  end
endmodule

// File: rtl/pcm_datapath.sv
module pcm_datapath
  import pcm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [LIN_W-1:0]  encLinear,
  input  logic [CODE_W-1:0] decByte,
  output logic [CODE_W-1:0] encByte,
  output logic [LIN_W-1:0]  decLinear
);
  // ---------------- encode ----------------
  logic              encNeg;
  logic [MAG_W-1:0]  encMag, muClip;
  logic [MAG_W:0]    muBiased;
  logic [MAG_W-2:0]  aMag, aShift;
  logic [MAG_W-1:0]  muShift;
  logic [SEG_W-1:0]  muSeg, aSeg, encSeg;
  logic [STEP_W-1:0] muStep, aStep, encStep;
  logic [CODE_W-1:0] encRaw, encNext;

  always_comb begin
    encNeg   = encLinear[LIN_W-1];
    encMag   = encNeg ? ~encLinear[MAG_W-1:0] : encLinear[MAG_W-1:0];
    muBiased = {1'b0, encMag} + MU_BIAS;
    muClip   = muBiased[MAG_W] ? {MAG_W{1'b1}} : muBiased[MAG_W-1:0];
    muSeg    = '0;
    for (int i = 0; i < 8; i++)
      if (muClip[i+5]) muSeg = SEG_W'(i);
    muShift  = muClip >> (4'(muSeg) + 4'd1);
    muStep   = muShift[STEP_W-1:0];

    aMag     = encMag[MAG_W-1:1];
    aSeg     = '0;
    for (int i = 1; i < 8; i++)
      if (aMag[i+4]) aSeg = SEG_W'(i);
    aShift   = aMag >> aSeg;
    aStep    = (aSeg == '0) ? aMag[4:1] : aShift[STEP_W-1:0];

    encSeg   = strobes.aLaw ? aSeg  : muSeg;
    encStep  = strobes.aLaw ? aStep : muStep;
    encRaw   = {~encNeg, encSeg, encStep};
    if (strobes.signMag)   encNext = encRaw;
    else if (strobes.aLaw) encNext = encRaw ^ ADI_MASK;
    else                   encNext = {encRaw[7], ~encRaw[6:0]};
  end

  // ---------------- decode ----------------
  logic [CODE_W-1:0] decRaw;
  logic [SEG_W-1:0]  decSeg;
  logic [STEP_W-1:0] decStep;
  logic [MAG_W:0]    muRecon;
  logic [MAG_W-1:0]  aRecon, decMag;
  logic [LIN_W-1:0]  decNext;

  always_comb begin
    if (strobes.signMag)   decRaw = decByte;
    else if (strobes.aLaw) decRaw = decByte ^ ADI_MASK;
    else                   decRaw = {decByte[7], ~decByte[6:0]};
    decSeg  = decRaw[6:4];
    decStep = decRaw[3:0];

    muRecon = (({9'd0, decStep, 1'b0} + MU_BIAS) << decSeg) - MU_BIAS;
    if (decSeg == '0)
      aRecon = {8'd0, decStep, 1'b1};
    else
      aRecon = ({8'd0, 1'b1, decStep} << decSeg) + (13'd1 << (decSeg - 3'd1));

    decMag  = strobes.aLaw ? {aRecon[MAG_W-2:0], 1'b0} : muRecon[MAG_W-1:0];
    decNext = decRaw[7] ? {1'b0, decMag} : ~{1'b0, decMag};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      encByte   <= '0;
      decLinear <= '0;
    end else begin
      if (strobes.encLoad) encByte   <= encNext;
      if (strobes.decLoad) decLinear <= decNext;
    end
  end
endmodule

// File: rtl/pcm_compander.sv
module pcm_compander
  import pcm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgALaw,
  input  logic        cfgSignMag,
  input  logic        encValid,
  input  logic [13:0] encLinear,
  output logic        encOutValid,
  output logic [7:0]  encByte,
  input  logic        decValid,
  input  logic [7:0]  decByte,
  output logic        decOutValid,
  output logic [13:0] decLinear
);
  ctlStrobes_t strobes;

  pcm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgALaw(cfgALaw),
    .cfgSignMag(cfgSignMag), .encValid(encValid), .decValid(decValid),
    .strobes(strobes), .encOutValid(encOutValid), .decOutValid(decOutValid)
  );

  pcm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .encLinear(encLinear),
    .decByte(decByte), .encByte(encByte), .decLinear(decLinear)
  );
endmodule

// File: rtl/pcm_compander_chk.sv
module pcm_compander_chk (
  input logic        clk,
  input logic        rstN,
  input logic        encValid,
  input logic [13:0] encLinear,
  input logic        encOutValid,
  input logic [7:0]  encByte,
  input logic        decValid,
  input logic [7:0]  decByte,
  input logic        decOutValid,
  input logic [13:0] decLinear
);
  always @(posedge clk)
    if (!rstN) p_quiet_in_reset_r1: assert (!encOutValid && !decOutValid);

  p_enc_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    encValid |=> encOutValid);
  p_enc_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !encValid |=> (!encOutValid && $stable(encByte)));
  p_dec_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> decOutValid);
  p_dec_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |=> (!decOutValid && $stable(decLinear)));
  // The sign bit is true sign under every law and coding combination.
  p_enc_sign_r2: assert property (@(posedge clk) disable iff (!rstN)
    encValid |=> (encByte[7] == !$past(encLinear[13])));
  p_dec_sign_r5: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> (decLinear[13] == !$past(decByte[7])));
endmodule

bind pcm_compander pcm_compander_chk u_chk (
  .clk(clk), .rstN(rstN), .encValid(encValid), .encLinear(encLinear),
  .encOutValid(encOutValid), .encByte(encByte), .decValid(decValid),
  .decByte(decByte), .decOutValid(decOutValid), .decLinear(decLinear)
);

// File: tb/pcm_compander_bench.sv
module pcm_compander_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0, cfgALaw = 1'b0, cfgSignMag = 1'b0;
  logic encValid = 1'b0, decValid = 1'b0;
  logic [13:0] encLinear = '0;
  logic [7:0]  decByte = '0;
  logic encOutValid, decOutValid;
  logic [7:0]  encByte;
  logic [13:0] decLinear;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pcm_compander u_pcm_compander (.*);

  function automatic logic [7:0] expEnc(int x, bit aLaw, bit sm);
    int m, s, st;
    bit pos;
    logic [7:0] raw;
    pos = (x >= 0);
    m = pos ? x : -x - 1;
    if (!aLaw) begin
      m = m + 33;
      if (m > 8191) m = 8191;
      s = 0;
      while (m >= (64 << s)) s++;
      st = (m >> (s + 1)) % 16;
    end else begin
      m = m / 2;
      if (m < 32) begin s = 0; st = m / 2; end
      else begin
        s = 1;
        while (m >= (32 << s)) s++;
        st = (m >> s) % 16;
      end
    end
    raw = {pos, 3'(s), 4'(st)};
    if (sm) return raw;
    if (aLaw) return raw ^ 8'h55;
    return {raw[7], ~raw[6:0]};
  endfunction

  function automatic logic [13:0] expDec(logic [7:0] b, bit aLaw, bit sm);
    logic [7:0] raw;
    int s, st, r;
    if (sm) raw = b;
    else if (aLaw) raw = b ^ 8'h55;
    else raw = {b[7], ~b[6:0]};
    s = int'(raw[6:4]);
    st = int'(raw[3:0]);
    if (!aLaw) r = ((2 * st + 33) << s) - 33;
    else if (s == 0) r = 2 * (2 * st + 1);
    else r = 2 * (((16 + st) << s) + (1 << (s - 1)));
    return raw[7] ? 14'(r) : 14'(-r - 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic writeCfg(bit a, bit s);
    cfgWrEn = 1; cfgALaw = a; cfgSignMag = s;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!encOutValid && !decOutValid, "R1 valids in reset", {encOutValid, decOutValid}, 0);
    rstN = 1;
    @(negedge clk);
    // R1 default + R9 ignored config inputs while strobe low
    cfgALaw = 1; cfgSignMag = 1;
    encValid = 1; encLinear = 14'd0; decValid = 1; decByte = 8'hFF;
    @(negedge clk);
    chk(encOutValid && encByte == 8'hFF, "R1/R9 default mu standard encode of 0", encByte, 8'hFF);
    chk(decOutValid && decLinear == 14'd0, "R1/R9 default mu standard decode 0xFF", decLinear, 0);
    // R10 clip points
    encLinear = 14'h1FFF;
    @(negedge clk);
    chk(encByte == 8'h80, "R10 clip positive", encByte, 8'h80);
    encLinear = 14'h2000;
    @(negedge clk);
    chk(encByte == 8'h00, "R10 clip negative", encByte, 8'h00);
    // R8 idle hold
    encValid = 0; decValid = 0; encLinear = 14'd100; decByte = 8'h12;
    @(negedge clk);
    chk(!encOutValid && encByte == 8'h00, "R8 enc hold", encByte, 8'h00);
    chk(!decOutValid && decLinear == 14'd0, "R8 dec hold", decLinear, 0);
    // R3 literal: A-law standard encoding of zero
    writeCfg(1, 0);
    encValid = 1; encLinear = 14'd0;
    @(negedge clk);
    chk(encByte == 8'hD5, "R3 A-law zero", encByte, 8'hD5);
    encValid = 0;
    // Exhaustive sweeps over all four modes
    for (int mode = 0; mode < 4; mode++) begin
      bit a, s;
      a = mode[1]; s = mode[0];
      writeCfg(a, s);
      encValid = 1;
      for (int x = -8192; x < 8192; x++) begin
        logic [7:0] e;
        encLinear = 14'(x);
        @(negedge clk);
        e = expEnc(x, a, s);
        if (s) chk(encOutValid && encByte == e, "R4 sign-mag encode", encByte, e);
        else if (a) chk(encOutValid && encByte == e, "R3 A-law encode", encByte, e);
        else chk(encOutValid && encByte == e, "R2 mu-law encode", encByte, e);
      end
      encValid = 0;
      decValid = 1;
      for (int b = 0; b < 256; b++) begin
        logic [13:0] e;
        decByte = 8'(b);
        @(negedge clk);
        e = expDec(8'(b), a, s);
        if (s) chk(decOutValid && decLinear == e, "R7 sign-mag decode", decLinear, e);
        else if (a) chk(decOutValid && decLinear == e, "R6 A-law decode", decLinear, e);
        else chk(decOutValid && decLinear == e, "R5 mu-law decode", decLinear, e);
      end
      decValid = 0;
      @(negedge clk);
      chk(!decOutValid, "R8 dec valid drops", decOutValid, 0);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule